// File: doc/BRIEF.md
# Multichannel Conversion Scan Sequencer

This block turns a one-byte conversion setup into a series of single-channel conversion requests for an external converter. A read request starts a sequence. For each step the block raises a request with a channel number, a differential flag and a bipolar flag. It holds the request until the converter answers with a done pulse and a result. Results go into an internal FIFO in the order they were converted. A consumer drains them over a valid/ready stream.

The setup byte chooses one of four scan patterns over four inputs. It also chooses single-ended inputs or two differential pairs. A separate input removes the reference pin (channel 3) from multichannel scans. A setup byte whose top bit is set belongs to a different register, and the block discards it.

The result stream follows these rules. `res_valid` stays high while the FIFO holds anything. `res_data` shows the oldest entry. An entry leaves the FIFO on a clock edge where both `res_valid` and `res_ready` are high. When the FIFO is full the sequencer issues no new request, so back-pressure pauses conversion and no result is lost.

Top module: `scan_sequencer`

## Requirements
- R1: After reset, `busy`, `conv_req` and `res_valid` are low. The setup holds the value 0x01: range scan, limit 0, single-ended. A read request then yields exactly one conversion, of channel 0.
- R2: The setup byte has these fields. Bits [6:5] select the mode. Bits [4:3] select readback. Bits [2:1] hold the limit N. Bit 0 = 1 selects single-ended. In mode 00 a read converts channels 0, 1, ... up to N, in ascending order.
- R3: Mode 01 converts channel N eight times in a row and returns eight results.
- R4: Mode 11 performs exactly one conversion, of channel N.
- R5: Mode 10 repeats the 0..N scan without end. Writing any setup byte with bit 7 = 0 ends it. The conversion in flight completes and is stored, no further request follows, and `busy` falls.
- R6: When `ref_excl` is 1, channel 3 is left out of modes 00 and 10. Modes 01 and 11 still convert channel 3 when N = 3.
- R7: With bit 0 = 0 the scan steps over pairs: pair 0 is channels 0/1 and pair 1 is channels 2/3. The limit N maps to pair N/2. Each request shows `conv_diff` = 1 and the pair's lower channel on `conv_chan` (0 or 2). When `ref_excl` is 1, pair 1 is left out of modes 00 and 10.
- R8: `conv_bipolar` follows `bip_sel` only for differential requests. Single-ended requests always show 0.
- R9: When bits [4:3] = 11, `readback_sel` is high. A read request then starts no conversion and `busy` stays low.
- R10: Results leave the FIFO in conversion order, each exactly once. While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` hold.
- R11: While the FIFO holds FIFO_DEPTH entries, no new request is raised and `busy` stays high. Taking results lets the sequence resume.
- R12: `busy` is high from the cycle after an accepted read request until the cycle after the last done. A read request while `busy` is high is ignored. `conv_req` is never high while `busy` is low.
- R13: A setup byte with bit 7 = 1 is ignored. The previous setup stays in force.
- R14: `conv_req` stays high, with `conv_chan` unchanged, until `conv_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Setup byte write strobe |
| cfg_byte | input | 8 | Setup byte; ignored when bit 7 is 1 |
| ref_excl | input | 1 | Leave channel 3 out of multichannel scans |
| bip_sel | input | 1 | Bipolar coding for differential conversions |
| rd_req | input | 1 | Start a conversion sequence |
| busy | output | 1 | Sequence in progress |
| readback_sel | output | 1 | Setup selects readback instead of conversion |
| conv_req | output | 1 | Conversion request, held until done |
| conv_chan | output | 2 | Channel, or the lower channel of the pair |
| conv_diff | output | 1 | Differential conversion |
| conv_bipolar | output | 1 | Bipolar conversion |
| conv_done | input | 1 | Converter finished, result valid |
| conv_data | input | DATA_W | Converter result |
| res_valid | output | 1 | Result FIFO not empty |
| res_ready | input | 1 | Consumer takes the head result |
| res_data | output | DATA_W | Head result |

## Verification
The bench builds the block with its default parameters: 12-bit data, an 8-entry FIFO and a repeat count of 8. Because the FIFO depth equals the repeat count, an undrained continuous scan fills the FIFO after eight conversions. That brings the full-FIFO stall and its release into reach in a short run. The converter model places a running sequence number in each result, so any loss, duplicate or reordering in the FIFO shows up at the stream.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int NUM_CH = 4;
  localparam int IDX_W  = $clog2(NUM_CH);
  localparam int CFG_W  = 7;

  typedef enum logic [1:0] {
    SCAN_RANGE  = 2'b00,
    SCAN_REPEAT = 2'b01,
    SCAN_LOOP   = 2'b10,
    SCAN_ONE    = 2'b11
  } scan_mode_e;

  typedef struct packed {
    scan_mode_e       mode;
    logic             readback;
    logic [IDX_W-1:0] target;
    logic [IDX_W-1:0] last;
    logic             diff;
    logic             bipolar;
  } scan_plan_t;
endpackage

// File: rtl/scan_cfg_decode.sv
module scan_cfg_decode
  import scan_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic             ref_excl,
  input  logic             bip_sel,
  output scan_plan_t       plan
);
  localparam logic [IDX_W-1:0] TOP_SE   = IDX_W'(NUM_CH - 1);
  localparam logic [IDX_W-1:0] TOP_PAIR = IDX_W'(NUM_CH / 2 - 1);

  logic             single;
  logic [IDX_W-1:0] lim;
  logic [IDX_W-1:0] top_idx;

  always_comb begin
    single  = cfg[0];
    lim     = cfg[IDX_W:1];
    top_idx = single ? TOP_SE : TOP_PAIR;
    plan.mode     = scan_mode_e'(cfg[6:5]);
    plan.readback = &cfg[4:3];
    plan.diff     = !single;
    plan.bipolar  = !single && bip_sel;
    plan.target   = single ? lim : (lim >> 1);
    if (ref_excl && plan.target == top_idx && plan.target != '0)
      plan.last = plan.target - IDX_W'(1);
    else
      plan.last = plan.target;
  end
endmodule

// File: rtl/scan_result_fifo.sv
module scan_result_fifo #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic              has_room,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              pop;

  assign pop       = out_valid && out_ready;
  assign out_valid = (count != '0);
  assign has_room  = (count < CNT_W'(DEPTH));
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/scan_stepper.sv
module scan_stepper
  import scan_pkg::*;
#(
  parameter int REPEATS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop_in,
  input  scan_plan_t       plan,
  input  logic             room,
  input  logic             conv_done,
  output logic             busy,
  output logic             conv_req,
  output logic             push,
  output logic [IDX_W-1:0] idx,
  output logic             diff,
  output logic             bipolar
);
  localparam int REP_W = (REPEATS > 1) ? $clog2(REPEATS) : 1;
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEATS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ROOM, ST_REQ} st_e;

  st_e              state;
  scan_mode_e       mode_q;
  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] idx_q;
  logic [REP_W-1:0] rep_q;
  logic             diff_q, bip_q, stop_q;
  logic             accept, halt, at_end, seq_end;

  assign accept   = (state == ST_IDLE) && start && !plan.readback;
  assign halt     = (mode_q == SCAN_LOOP) && (stop_q || stop_in);
  assign busy     = (state != ST_IDLE);
  assign conv_req = (state == ST_REQ);
  assign push     = conv_req && conv_done;
  assign idx      = idx_q;
  assign diff     = diff_q;
  assign bipolar  = bip_q;

  always_comb begin
    at_end  = (idx_q == last_q);
    seq_end = 1'b0;
    case (mode_q)
      SCAN_RANGE:  seq_end = at_end;
      SCAN_REPEAT: seq_end = (rep_q == REP_LAST);
      SCAN_ONE:    seq_end = 1'b1;
      default:     seq_end = halt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= SCAN_RANGE;
      last_q <= '0;
      idx_q  <= '0;
      rep_q  <= '0;
      diff_q <= 1'b0;
      bip_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            mode_q <= plan.mode;
            last_q <= plan.last;
            diff_q <= plan.diff;
            bip_q  <= plan.bipolar;
            idx_q  <= (plan.mode == SCAN_RANGE || plan.mode == SCAN_LOOP) ? '0 : plan.target;
            rep_q  <= '0;
            stop_q <= 1'b0;
            state  <= ST_ROOM;
          end
        end
        ST_ROOM: begin
          if (halt)      state <= ST_IDLE;
          else if (room) state <= ST_REQ;
        end
        default: begin
          if (stop_in && mode_q == SCAN_LOOP) stop_q <= 1'b1;
          if (conv_done) begin
            if (seq_end) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_ROOM;
              if (mode_q == SCAN_REPEAT) rep_q <= rep_q + REP_W'(1);
              else if (at_end)           idx_q <= '0;
              else                       idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int FIFO_DEPTH = 8,
  parameter int REPEATS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_byte,
  input  logic              ref_excl,
  input  logic              bip_sel,
  input  logic              rd_req,
  output logic              busy,
  output logic              readback_sel,
  output logic              conv_req,
  output logic [1:0]        conv_chan,
  output logic              conv_diff,
  output logic              conv_bipolar,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data
);
  localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'(1);

  logic [CFG_W-1:0] cfg_q;
  logic             cfg_take;
  scan_plan_t       plan;
  logic             room, push;
  logic [IDX_W-1:0] idx;

  assign cfg_take = cfg_wr && !cfg_byte[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= CFG_RESET;
    else if (cfg_take) cfg_q <= cfg_byte[CFG_W-1:0];
  end

  scan_cfg_decode u_dec (
    .cfg      (cfg_q),
    .ref_excl (ref_excl),
    .bip_sel  (bip_sel),
    .plan     (plan)
  );

  scan_stepper #(.REPEATS(REPEATS)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (rd_req),
    .stop_in   (cfg_take),
    .plan      (plan),
    .room      (room),
    .conv_done (conv_done),
    .busy      (busy),
    .conv_req  (conv_req),
    .push      (push),
    .idx       (idx),
    .diff      (conv_diff),
    .bipolar   (conv_bipolar)
  );

  assign conv_chan    = conv_diff ? {idx[0], 1'b0} : idx;
  assign readback_sel = plan.readback;

  scan_result_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (conv_data),
    .has_room  (room),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (res_data)
  );
endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              conv_req,
  input logic [1:0]        conv_chan,
  input logic              conv_diff,
  input logic              conv_bipolar,
  input logic              conv_done,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req); // R14
  AST_CHAN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> $stable(conv_chan)); // R14
  AST_SE_UNIPOLAR: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_diff |-> !conv_bipolar); // R8
  AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_diff |-> !conv_chan[0]); // R7
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> busy); // R12
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data)); // R10
endmodule

bind scan_sequencer scan_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .conv_req     (conv_req),
  .conv_chan    (conv_chan),
  .conv_diff    (conv_diff),
  .conv_bipolar (conv_bipolar),
  .conv_done    (conv_done),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_data     (res_data)
);

// File: tb/tb_scan_sequencer.sv
module tb_scan_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [7:0]    cfg_byte = '0;
  logic          ref_excl = 1'b0;
  logic          bip_sel = 1'b0;
  logic          rd_req = 1'b0;
  logic          busy, readback_sel, conv_req, conv_diff, conv_bipolar, res_valid;
  logic [1:0]    conv_chan;
  logic          conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic          res_ready = 1'b1;
  logic [DW-1:0] res_data;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] log_q[$];
  logic [DW-1:0] got_q[$];
  int seq = 0;
  int lat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
    .ref_excl(ref_excl), .bip_sel(bip_sel), .rd_req(rd_req), .busy(busy),
    .readback_sel(readback_sel), .conv_req(conv_req), .conv_chan(conv_chan),
    .conv_diff(conv_diff), .conv_bipolar(conv_bipolar), .conv_done(conv_done),
    .conv_data(conv_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data)
  );

  // converter model: answers two cycles after a request is seen
  initial begin
    forever begin
      @(negedge clk);
      if (conv_done) begin
        conv_done = 1'b0;
      end else if (conv_req) begin
        lat++;
        if (lat == 2) begin
          lat = 0;
          conv_data = {conv_diff, conv_bipolar, conv_chan, seq[7:0]};
          log_q.push_back(conv_data);
          seq++;
          conv_done = 1'b1;
        end
      end
    end
  end

  // stream sink
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (res_valid && res_ready) got_q.push_back(res_data);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] b);
    @(negedge clk); cfg_wr = 1'b1; cfg_byte = b;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic clear_logs();
    @(negedge clk);
    log_q.delete(); got_q.delete(); seq = 0;
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 3000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    chk(!busy, req, busy, 0);
  endtask

  task automatic drain();
    repeat (20) @(negedge clk);
  endtask

  // compare the conversion log and the stream against the expected channels
  task automatic check_run(input string req, input int exp_ch[$], input bit e_diff, input bit e_bip);
    chk(log_q.size() == exp_ch.size(), req, log_q.size(), exp_ch.size());
    chk(got_q.size() == log_q.size(), "R10", got_q.size(), log_q.size());
    for (int i = 0; i < log_q.size() && i < exp_ch.size(); i++) begin
      chk(log_q[i][9:8] == exp_ch[i][1:0], req, log_q[i][9:8], exp_ch[i]);
      chk(log_q[i][11] == e_diff, req, log_q[i][11], e_diff);
      chk(log_q[i][10] == e_bip, "R8", log_q[i][10], e_bip);
    end
    for (int i = 0; i < got_q.size(); i++)
      chk(got_q[i][7:0] == i[7:0], "R10", got_q[i][7:0], i);
  endtask

  task automatic run_one(input string req, input logic [7:0] cfg, input bit rx, input bit bp,
                         input int exp_ch[$], input bit e_diff, input bit e_bip);
    write_cfg(cfg);
    ref_excl = rx; bip_sel = bp; res_ready = 1'b1;
    clear_logs();
    pulse_rd();
    wait_idle(req);
    drain();
    check_run(req, exp_ch, e_diff, e_bip);
  endtask

  task automatic t_reset();  // R1
    chk(!busy, "R1", busy, 0);
    chk(!conv_req, "R1", conv_req, 0);
    chk(!res_valid, "R1", res_valid, 0);
    clear_logs();
    pulse_rd();
    wait_idle("R1");
    drain();
    check_run("R1", '{0}, 1'b0, 1'b0);
  endtask

  task automatic t_modes();
    run_one("R2", 8'h05, 1'b0, 1'b0, '{0, 1, 2}, 1'b0, 1'b0);
    run_one("R3", 8'h23, 1'b0, 1'b0, '{1, 1, 1, 1, 1, 1, 1, 1}, 1'b0, 1'b0);
    run_one("R4", 8'h65, 1'b0, 1'b0, '{2}, 1'b0, 1'b0);
  endtask

  task automatic t_ref_skip();  // R6
    run_one("R6", 8'h07, 1'b1, 1'b0, '{0, 1, 2}, 1'b0, 1'b0);
    run_one("R6", 8'h07, 1'b0, 1'b0, '{0, 1, 2, 3}, 1'b0, 1'b0);
    run_one("R6", 8'h67, 1'b1, 1'b0, '{3}, 1'b0, 1'b0);
    run_one("R6", 8'h27, 1'b1, 1'b0, '{3, 3, 3, 3, 3, 3, 3, 3}, 1'b0, 1'b0);
  endtask

  task automatic t_diff();  // R7 R8
    run_one("R7", 8'h06, 1'b0, 1'b1, '{0, 2}, 1'b1, 1'b1);
    run_one("R7", 8'h06, 1'b1, 1'b1, '{0}, 1'b1, 1'b1);
    run_one("R7", 8'h64, 1'b0, 1'b0, '{2}, 1'b1, 1'b0);
    run_one("R8", 8'h03, 1'b0, 1'b1, '{0, 1}, 1'b0, 1'b0);
  endtask

  task automatic t_readback();  // R9
    write_cfg(8'h19);
    clear_logs();
    chk(readback_sel, "R9", readback_sel, 1);
    pulse_rd();
    for (int i = 0; i < 20; i++) begin
      if (busy || conv_req) begin
        chk(1'b0, "R9", busy, 0);
        break;
      end
      @(negedge clk);
    end
    chk(log_q.size() == 0, "R9", log_q.size(), 0);
  endtask

  task automatic t_ignore_setup();  // R13
    write_cfg(8'h05);
    write_cfg(8'hE3);
    ref_excl = 1'b0; bip_sel = 1'b0;
    clear_logs();
    pulse_rd();
    wait_idle("R13");
    drain();
    check_run("R13", '{0, 1, 2}, 1'b0, 1'b0);
  endtask

  task automatic t_busy();  // R12
    write_cfg(8'h07);
    ref_excl = 1'b0;
    clear_logs();
    pulse_rd();
    chk(busy, "R12", busy, 1);
    repeat (3) @(negedge clk);
    pulse_rd();
    wait_idle("R12");
    drain();
    check_run("R12", '{0, 1, 2, 3}, 1'b0, 1'b0);
  endtask

  task automatic t_loop();  // R5
    int n;
    write_cfg(8'h43);
    ref_excl = 1'b0; res_ready = 1'b1;
    clear_logs();
    pulse_rd();
    for (int i = 0; i < 500 && log_q.size() < 7; i++) @(negedge clk);
    chk(log_q.size() >= 7, "R5", log_q.size(), 7);
    write_cfg(8'h01);
    wait_idle("R5");
    n = log_q.size();
    drain();
    chk(log_q.size() == n, "R5", log_q.size(), n);
    chk(got_q.size() == n, "R5", got_q.size(), n);
    for (int i = 0; i < log_q.size(); i++)
      chk(log_q[i][9:8] == 2'(i % 2), "R5", log_q[i][9:8], i % 2);
  endtask

  task automatic t_backpressure();  // R11
    int n;
    logic [DW-1:0] head;
    write_cfg(8'h47);
    ref_excl = 1'b0; res_ready = 1'b0;
    clear_logs();
    pulse_rd();
    repeat (60) @(negedge clk);
    chk(log_q.size() == 8, "R11", log_q.size(), 8);
    chk(!conv_req, "R11", conv_req, 0);
    chk(busy, "R11", busy, 1);
    chk(res_valid, "R10", res_valid, 1);
    head = res_data;
    chk(head[7:0] == 8'd0, "R10", head[7:0], 0);
    res_ready = 1'b1;
    for (int i = 0; i < 500 && log_q.size() < 13; i++) @(negedge clk);
    chk(log_q.size() >= 13, "R11", log_q.size(), 13);
    write_cfg(8'h01);
    wait_idle("R11");
    drain();
    n = log_q.size();
    chk(got_q.size() == n, "R11", got_q.size(), n);
    for (int i = 0; i < got_q.size() && i < n; i++) begin
      chk(got_q[i] == log_q[i], "R10", got_q[i], log_q[i]);
      chk(log_q[i][9:8] == 2'(i % 4), "R11", log_q[i][9:8], i % 4);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_ref_skip();
    t_diff();
    t_readback();
    t_ignore_setup();
    t_busy();
    t_loop();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule